// File: doc/BRIEF.md
# Two-Level Interrupt Request Controller

This controller gathers five interrupt sources: two active-low external pins, two timer overflow flags and one serial-port request. It passes at most one of them to a CPU core. Every source must pass a master enable and its own enable bit. It is then ranked by a per-source priority bit. Within one level, the source with the lower index wins. The winner is shown as a request line, a 3-bit source index and its level. All of these outputs are combinational from the inputs and the registered state.

Each external pin has its own trigger-mode bit, which selects falling-edge or low-level detection. In edge mode a latched flag holds the event until the CPU acknowledges that source. The CPU programs three bytes through a write strobe: enable, priority and trigger control. It signals entry into a handler with an acknowledge pulse and the end of a handler with a return pulse. The controller keeps one in-service bit per level. These bits decide which new requests may interrupt the running handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, irq_o, in_service_o and ext_flag_o are all 0. The enable, priority and control bytes are 0, so both external inputs are in level mode.
- R2: While bit 7 of the enable byte is 0, irq_o stays 0 whatever the other bits and the requests are.
- R3: Enable-byte bits 0 to 4 gate, in that order, external 0, timer 0, external 1, timer 1 and serial. A source whose bit is 0 is never presented. Bits 5 and 6 have no effect.
- R4: Among the presented candidates of one level, the lowest source index wins. The indices are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3 and serial = 4. The winner appears on irq_id_o.
- R5: A priority-byte bit of 1 puts that source on the high level (irq_lvl_o = 1). A high candidate beats any low candidate.
- R6: When control bit 0 (for external 0) or bit 1 (for external 1) is 1, a high-to-low transition of the pin sets the flag on the second rising clock edge after it. The flag stays set after the pin returns high.
- R7: When the control bit is 0, the flag follows the inverted pin with the same two-edge latency. An acknowledge does not clear it.
- R8: An acknowledge while irq_o is 1 sets the in-service bit of the presented level at the next edge. If the acknowledged source is an external input in edge mode, its flag is also cleared at that edge.
- R9: While the high in-service bit is set, irq_o is 0. While only the low in-service bit is set, only high-level requests are presented.
- R10: A return pulse clears the high in-service bit if it is set. Otherwise it clears the low bit.
- R11: An acknowledge while irq_o is 0 leaves in_service_o and the edge flags unchanged.
- R12: Writes take effect at the next edge: select 0 writes the enable byte, 1 the priority byte, 2 the control byte, and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 enable, 1 priority, 2 control |
| wr_data_i | input | 8 | Write data |
| ext_ni | input | 2 | External request pins, active low |
| tmr_ovf_i | input | 2 | Timer 0 and timer 1 overflow flags |
| ser_req_i | input | 1 | Serial port request |
| ack_i | input | 1 | CPU takes the presented request |
| reti_i | input | 1 | CPU leaves the current handler |
| irq_o | output | 1 | A request is presented |
| irq_id_o | output | 3 | Index of the presented source |
| irq_lvl_o | output | 1 | Level of the presented source |
| in_service_o | output | 2 | In-service bits, bit 1 high, bit 0 low |
| ext_flag_o | output | 2 | External request flags |

## Verification
A corrupted in-service bit shows on irq_o at the very next comparison. A stuck high bit silences every request, and a lost low bit lets a same-level request through. A wrong edge flag shows on ext_flag_o, and on the index, two edges after the pin moves. A missed clear on acknowledge keeps the same index on irq_id_o after the handler returns. The reference model checks every output at every clock, across directed sequences and a long randomised stretch of writes, requests, acknowledges and returns.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned SRC_W    = $clog2(NUM_SRC);
  localparam int unsigned NUM_EXT  = 2;
  localparam int unsigned NUM_TMR  = 2;
  localparam int unsigned NUM_LVL  = 2;
  localparam int unsigned LVL_W    = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned EA_BIT   = 7;
  localparam int unsigned SER_POS  = 4;
  localparam logic [BYTE_W-1:0] EN_MASK = 8'h9F;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_PRIO = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  // interleaved layout: ext0, tmr0, ext1, tmr1, serial
  function automatic int unsigned ext_pos(int unsigned e);
    return 2 * e;
  endfunction

  function automatic int unsigned tmr_pos(int unsigned t);
    return 2 * t + 1;
  endfunction
endpackage

// File: rtl/irq_ext_trig.sv
module irq_ext_trig #(
  parameter int unsigned NUM_EXT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] pin_ni,
  input  logic [NUM_EXT-1:0] edge_mode_i,
  input  logic [NUM_EXT-1:0] clr_i,
  output logic [NUM_EXT-1:0] flag_o
);
  logic [NUM_EXT-1:0] smp_q, prv_q, flag_q;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    logic fall;
    assign fall = prv_q[e] & ~smp_q[e];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q[e]  <= 1'b1;
        prv_q[e]  <= 1'b1;
        flag_q[e] <= 1'b0;
      end else begin
        smp_q[e] <= pin_ni[e];
        prv_q[e] <= smp_q[e];
        if (edge_mode_i[e]) begin
          // a new edge wins over a same-cycle clear
          if (fall)          flag_q[e] <= 1'b1;
          else if (clr_i[e]) flag_q[e] <= 1'b0;
        end else begin
          flag_q[e] <= ~smp_q[e];
        end
      end
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned W     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [W-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_lvl_track.sv
module irq_lvl_track #(
  parameter int unsigned NUM_LVL = 2,
  parameter int unsigned LVL_W   = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [LVL_W-1:0]   take_lvl_i,
  input  logic               ret_i,
  output logic [NUM_LVL-1:0] ins_o
);
  logic [NUM_LVL-1:0] ins_q, ins_d;

  always_comb begin
    int unsigned top;
    logic        found;
    ins_d = ins_q;
    top   = 0;
    found = 1'b0;
    for (int unsigned l = 0; l < NUM_LVL; l++) begin
      if (ins_q[l]) begin
        top   = l;
        found = 1'b1;
      end
    end
    if (ret_i && found) ins_d[top] = 1'b0;
    if (take_i)         ins_d[take_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ins_q <= '0;
    else         ins_q <= ins_d;
  end

  assign ins_o = ins_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [BYTE_W-1:0]  wr_data_i,
  input  logic [NUM_EXT-1:0] ext_ni,
  input  logic [NUM_TMR-1:0] tmr_ovf_i,
  input  logic               ser_req_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [SRC_W-1:0]   irq_id_o,
  output logic [LVL_W-1:0]   irq_lvl_o,
  output logic [NUM_LVL-1:0] in_service_o,
  output logic [NUM_EXT-1:0] ext_flag_o
);
  logic [BYTE_W-1:0]  en_q;
  src_vec_t           prio_q;
  logic [NUM_EXT-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      prio_q <= '0;
      mode_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_sel_e'(wr_sel_i))
        SEL_EN:   en_q   <= wr_data_i & EN_MASK;
        SEL_PRIO: prio_q <= wr_data_i[NUM_SRC-1:0];
        SEL_CTRL: mode_q <= wr_data_i[NUM_EXT-1:0];
        default:  ;
      endcase
    end
  end

  logic [NUM_EXT-1:0] flag;
  logic [NUM_EXT-1:0] ext_clr;
  logic [NUM_LVL-1:0] ins;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_clr
    assign ext_clr[e] = ack_i & irq_o & (irq_id_o == SRC_W'(ext_pos(e)));
  end

  irq_ext_trig #(.NUM_EXT(NUM_EXT)) u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_ni      (ext_ni),
    .edge_mode_i (mode_q),
    .clr_i       (ext_clr),
    .flag_o      (flag)
  );

  src_vec_t pend, elig;

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_pend_ext
    assign pend[ext_pos(e)] = flag[e];
  end
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_pend_tmr
    assign pend[tmr_pos(t)] = tmr_ovf_i[t];
  end
  assign pend[SER_POS] = ser_req_i;

  assign elig = en_q[EA_BIT] ? (pend & en_q[NUM_SRC-1:0]) : '0;

  src_vec_t           cand    [NUM_LVL];
  logic [NUM_LVL-1:0] lvl_any;
  logic [SRC_W-1:0]   lvl_idx [NUM_LVL];

  for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
    logic open;
    // a level may be presented only when no handler at it or above runs
    assign open     = ~|ins[NUM_LVL-1:lv];
    assign cand[lv] = (lv == 0) ? (elig & ~prio_q & {NUM_SRC{open}})
                                : (elig &  prio_q & {NUM_SRC{open}});
    irq_pick #(.W(NUM_SRC), .IDX_W(SRC_W)) u_pick (
      .req_i (cand[lv]),
      .any_o (lvl_any[lv]),
      .idx_o (lvl_idx[lv])
    );
  end

  always_comb begin
    irq_o     = 1'b0;
    irq_id_o  = '0;
    irq_lvl_o = '0;
    for (int unsigned lv = 0; lv < NUM_LVL; lv++) begin
      if (lvl_any[lv]) begin
        irq_o     = 1'b1;
        irq_id_o  = lvl_idx[lv];
        irq_lvl_o = LVL_W'(lv);
      end
    end
  end

  irq_lvl_track #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (ack_i & irq_o),
    .take_lvl_i (irq_lvl_o),
    .ret_i      (reti_i),
    .ins_o      (ins)
  );

  assign in_service_o = ins;
  assign ext_flag_o   = flag;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_i,
  input logic       reti_i,
  input logic       irq_o,
  input logic [2:0] irq_id_o,
  input logic       irq_lvl_o,
  input logic [1:0] in_service_o,
  input logic       ea_i
);
  // R2
  ea_off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ea_i |-> !irq_o);

  // R4
  id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_id_o < 3'd5));

  // R9
  hi_busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_service_o[1] |-> !irq_o);

  // R9
  lo_busy_hi_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_service_o[0] && irq_o) |-> irq_lvl_o);

  // R8
  ack_hi_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && irq_lvl_o) |=> in_service_o[1]);

  // R8
  ack_lo_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !irq_lvl_o && !reti_i) |=> in_service_o[0]);

  // R10
  ret_drops_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && in_service_o[1]) |=> !in_service_o[1]);

  // R11
  stray_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !reti_i) |=> $stable(in_service_o));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_i        (ack_i),
  .reti_i       (reti_i),
  .irq_o        (irq_o),
  .irq_id_o     (irq_id_o),
  .irq_lvl_o    (irq_lvl_o),
  .in_service_o (in_service_o),
  .ea_i         (en_q[7])
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] ext_n = 2'b11;
  logic [1:0] tmr = 2'b00;
  logic       ser = 1'b0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic       irq;
  logic [2:0] irq_id;
  logic       irq_lvl;
  logic [1:0] ins;
  logic [1:0] flg;

  always #10ns clk = ~clk;

  irq_prio_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .ext_ni(ext_n), .tmr_ovf_i(tmr), .ser_req_i(ser),
    .ack_i(ack), .reti_i(reti), .irq_o(irq), .irq_id_o(irq_id),
    .irq_lvl_o(irq_lvl), .in_service_o(ins), .ext_flag_o(flg)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // reference model state
  bit [7:0] m_en, m_prio, m_ctrl;
  bit [1:0] m_ins, m_flag, m_s1, m_s2;
  bit       m_irq, m_lvl;
  int       m_id;

  task automatic check(string t, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  function automatic void m_reset();
    m_en = 0; m_prio = 0; m_ctrl = 0; m_ins = 0; m_flag = 0;
    m_s1 = 2'b11; m_s2 = 2'b11;
  endfunction

  function automatic void m_eval();
    bit [4:0] p, el;
    p = {ser, tmr[1], m_flag[1], tmr[0], m_flag[0]};
    el = m_en[7] ? (p & m_en[4:0]) : 5'd0;
    m_irq = 0; m_id = 0; m_lvl = 0;
    if (!m_ins[1])
      for (int i = 0; i < 5; i++)
        if (!m_irq && el[i] && m_prio[i]) begin m_irq = 1; m_id = i; m_lvl = 1; end
    if (!m_irq && m_ins == 2'b00)
      for (int i = 0; i < 5; i++)
        if (!m_irq && el[i] && !m_prio[i]) begin m_irq = 1; m_id = i; m_lvl = 0; end
  endfunction

  function automatic void m_update();
    int took;
    took = (ack && m_irq) ? m_id : -1;
    for (int e = 0; e < 2; e++) begin
      if (m_ctrl[e]) begin
        if (m_s2[e] && !m_s1[e]) m_flag[e] = 1;
        else if (took == 2 * e)  m_flag[e] = 0;
      end else begin
        m_flag[e] = !m_s1[e];
      end
      m_s2[e] = m_s1[e];
      m_s1[e] = ext_n[e];
    end
    if (reti) begin
      if (m_ins[1]) m_ins[1] = 0;
      else          m_ins[0] = 0;
    end
    if (ack && m_irq) m_ins[m_lvl] = 1;
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_en = wr_data & 8'h9F;
        2'd1: m_prio = {3'b000, wr_data[4:0]};
        2'd2: m_ctrl = {6'b0, wr_data[1:0]};
        default: ;
      endcase
    end
  endfunction

  task automatic step();
    #2;
    m_eval();
    check(tag, irq, m_irq, "irq_o");
    if (m_irq) begin
      check(tag, irq_id, m_id, "irq_id_o");
      check(tag, irq_lvl, m_lvl, "irq_lvl_o");
    end
    check(tag, ins, m_ins, "in_service_o");
    check(tag, flg, m_flag, "ext_flag_o");
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(bit [1:0] s, bit [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    step();
    wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic pulse_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic pulse_ret();
    reti = 1; step(); reti = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    tag = "R1";
    check("R1", irq, 0, "irq_o after reset");
    check("R1", ins, 0, "in_service_o after reset");
    check("R1", flg, 0, "ext_flag_o after reset");
    steps(2);

    // master enable off blocks everything
    tag = "R2";
    ext_n = 2'b00; tmr = 2'b11; ser = 1;
    wr(2'd0, 8'h7F);
    steps(4);
    check("R2", irq, 0, "irq_o with master off");

    // fixed order inside a level
    tag = "R4";
    wr(2'd0, 8'h9F);
    step();
    check("R4", irq_id, 0, "ext0 wins");
    ext_n[0] = 1;
    steps(3);
    check("R4", irq_id, 1, "timer0 next");

    tag = "R3";
    wr(2'd0, 8'hF0);
    step();
    check("R3", irq_id, 4, "serial only");

    tag = "R12";
    wr(2'd3, 8'h00);
    step();
    check("R12", irq_id, 4, "select 3 writes nothing");

    tag = "R5";
    wr(2'd0, 8'h9F);
    wr(2'd1, 8'h10);
    step();
    check("R5", irq_id, 4, "high serial beats low");
    check("R5", irq_lvl, 1, "level high");

    tag = "R8";
    pulse_ack();
    check("R8", ins, 2'b10, "high in service");
    tag = "R9";
    step();
    check("R9", irq, 0, "blocked under high");
    tag = "R10";
    pulse_ret();
    check("R10", ins, 2'b00, "return clears high");

    // preemption of a low handler
    tag = "R9";
    ext_n = 2'b11; tmr = 0; ser = 0;
    wr(2'd1, 8'h08);
    steps(3);
    tmr[0] = 1;
    step();
    pulse_ack();
    check("R9", ins, 2'b01, "low in service");
    check("R9", irq, 0, "low blocked under low");
    tmr[1] = 1;
    step();
    check("R9", irq_id, 3, "high preempts");
    pulse_ack();
    check("R9", ins, 2'b11, "both in service");
    tag = "R10";
    pulse_ret();
    check("R10", ins, 2'b01, "high cleared first");
    tmr = 0;
    pulse_ret();
    check("R10", ins, 2'b00, "low cleared");

    // edge mode on ext0
    tag = "R6";
    wr(2'd2, 8'h01);
    steps(3);
    ext_n[0] = 0;
    step();
    ext_n[0] = 1;
    steps(3);
    check("R6", flg[0], 1, "edge flag held");
    check("R6", irq_id, 0, "ext0 presented");
    tag = "R8";
    pulse_ack();
    check("R8", flg[0], 0, "edge flag cleared by ack");
    check("R8", ins, 2'b01, "low in service");
    pulse_ret();

    // level mode on ext1
    tag = "R7";
    wr(2'd2, 8'h00);
    ext_n[1] = 0;
    steps(3);
    check("R7", flg[1], 1, "level flag");
    pulse_ack();
    check("R7", flg[1], 1, "level flag kept");
    ext_n[1] = 1;
    pulse_ret();
    steps(3);

    tag = "R11";
    wr(2'd0, 8'h1F);
    step();
    pulse_ack();
    check("R11", ins, 2'b00, "stray ack");

    // randomised mix
    tag = "R4";
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom;
      ext_n = r[1:0] | r[3:2];
      tmr = r[5:4] & r[7:6];
      ser = r[8] & r[9];
      ack = r[10];
      reti = (r[13:11] == 0);
      wr_en = (r[17:14] == 0);
      wr_sel = r[19:18];
      wr_data = r[27:20] | {r[28], 7'd0};
      step();
    end
    ack = 0; reti = 0; wr_en = 0;
    steps(2);

    done = 1;
    summary();
    $finish;
  end
endmodule